// File: doc/BRIEF.md
# Edge-capture timer channel

This block is a single counter channel that timestamps edges. A free-running up-counter advances on a selectable tick: every clock, one of three prescaled rates, or the edges of a slow external clock. The tick can be gated by a level input. Edges on input A copy the counter into capture register A and then into capture register B, in that order. This lets software measure pulse widths and periods with no cycle-level timing work. The counter can restart on a software command, on a selected edge of input A or input B, or when it matches a compare value C.

Event flags record captures, overwrites of unread captures, compare matches, counter wrap and external restarts. Reading the flag word clears them. An interrupt line is raised for any flag whose mask bit is set. Both capture inputs are only sampled, through two flip-flops each. The block has a simple single-cycle register port with word addresses: 0 control (write), 1 mode, 2 counter (read), 3 capture A (read), 4 capture B (read), 5 compare C, 6 flags (read), 7 mask set (write), 8 mask clear (write), 9 mask (read).

Top module: `capture_timer`

## Requirements
- R1: Writing the control word with bit0 set starts the counter and bit1 stops it; bit1 wins if both are set. Bit2 restarts the counter at 0. While stopped, the counter holds its value.
- R2: Mode bits [2:0] choose the tick: 0 means every clock, 1, 2 and 3 mean every 4th, 16th and 64th clock, and 4 to 7 mean rising edges of the external clock. Mode bit3 changes that to falling edges. With mode bit4 set, the counter advances only while the gate input is high.
- R3: A tick at the all-ones value wraps the counter to 0 and sets flag bit0.
- R4: A tick while the counter equals compare C sets flag bit4. With mode bit10 set, that tick restarts the counter at 0, so it runs from 0 to C.
- R5: Mode bits [12:11] select the input-A edge that loads capture A, and bits [14:13] the edge that loads capture B. The codes are 0 none, 1 rising, 2 falling, 3 both. Capture B loads only after capture A. Each load stores the counter value and sets flag bit5 (A) or bit6 (B).
- R6: Flag bit1 is set when a capture register is loaded again before it has been read.
- R7: After a capture B load, mode bit5 freezes the counter until the next restart, and mode bit6 turns the counter off.
- R8: Mode bits [8:7] select the restart edge, with the same codes as R5. The edge comes from input B, or from input A when mode bit9 is set. Such an edge restarts the counter at 0, sets flag bit7 and lets capture A load next.
- R9: Reading the flag word returns the event flags in bits [7:0] and clears them. Bit16 shows that the counter is on, and bits 17 and 18 show the synchronized levels of inputs A and B.
- R10: Writing address 7 sets mask bits and writing address 8 clears them. The interrupt output is high while any flag in bits [7:0] has its mask bit set.
- R11: After reset, the counter, the flags, the mask, the mode and the interrupt output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | Slow external tick source |
| ext_gate | input | 1 | Count gate level |
| in_a | input | 1 | Capture input A (sampled only) |
| in_b | input | 1 | Trigger input B (sampled only) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions watch, on every cycle, that a stopped counter holds its value, that the counter wraps with its flag, and that a compare restart returns the counter to zero. They also check that a capture B load stores the counter and re-arms capture A, that an overwrite of an unread capture raises the overrun flag, and that the off-on-load option clears the run state. Edge-code decoding, the A-then-B ordering across whole pulses, prescaler rates, external clock polarity, gating, trigger source selection and read-to-clear flags only show up across multi-cycle scenarios, so the bench drives those.

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int CW       = 16,
  parameter int DIV1_LOG = 2,
  parameter int DIV2_LOG = 4,
  parameter int DIV3_LOG = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_clk,
  input  logic        ext_gate,
  input  logic        in_a,
  input  logic        in_b,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam logic [3:0] A_CTRL = 4'd0, A_MODE = 4'd1, A_CV = 4'd2, A_RA = 4'd3,
                         A_RB = 4'd4, A_RC = 4'd5, A_ST = 4'd6, A_MSET = 4'd7,
                         A_MCLR = 4'd8, A_MASK = 4'd9;
  localparam int ZW = 32 - CW;

  function automatic logic edge_hit(input logic [1:0] code, input logic r, input logic f);
    return (code[0] & r) | (code[1] & f);
  endfunction

  logic [2:0] a_sh, b_sh, x_sh;
  logic [1:0] g_sh;
  logic [DIV3_LOG-1:0] psc_q;
  logic [14:0] mode_q;
  logic [CW-1:0] cv_q, ra_q, rb_q, rc_q;
  logic [7:0] st_q, mask_q;
  logic clk_en_q, stop_q, ra_seq_q, ra_unread_q, rb_unread_q;

  wire a_rise = a_sh[1] & ~a_sh[2];
  wire a_fall = ~a_sh[1] & a_sh[2];
  wire b_rise = b_sh[1] & ~b_sh[2];
  wire b_fall = ~b_sh[1] & b_sh[2];
  wire x_rise = x_sh[1] & ~x_sh[2];
  wire x_fall = ~x_sh[1] & x_sh[2];

  wire [2:0] clksel   = mode_q[2:0];
  wire       clk_inv  = mode_q[3];
  wire       gate_on  = mode_q[4];
  wire       ldb_stop = mode_q[5];
  wire       ldb_dis  = mode_q[6];
  wire [1:0] trg_edge = mode_q[8:7];
  wire       trg_src_a = mode_q[9];
  wire       rc_trg   = mode_q[10];
  wire [1:0] ra_edge  = mode_q[12:11];
  wire [1:0] rb_edge  = mode_q[14:13];

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire sw_en   = wr_ctrl & bus_wdata[0];
  wire sw_dis  = wr_ctrl & bus_wdata[1];
  wire sw_trg  = wr_ctrl & bus_wdata[2];
  wire rd_ra   = bus_rd && bus_addr == A_RA;
  wire rd_rb   = bus_rd && bus_addr == A_RB;
  wire rd_st   = bus_rd && bus_addr == A_ST;
  wire unused_wdata = ^bus_wdata[31:CW];

  logic tick;
  always_comb begin
    case (clksel)
      3'd0:    tick = 1'b1;
      3'd1:    tick = &psc_q[DIV1_LOG-1:0];
      3'd2:    tick = &psc_q[DIV2_LOG-1:0];
      3'd3:    tick = &psc_q[DIV3_LOG-1:0];
      default: tick = clk_inv ? x_fall : x_rise;
    endcase
  end

  wire step    = clk_en_q & ~stop_q & tick & (~gate_on | g_sh[1]);
  wire ext_trg = trg_src_a ? edge_hit(trg_edge, a_rise, a_fall)
                           : edge_hit(trg_edge, b_rise, b_fall);
  wire rc_hit  = step & (cv_q == rc_q);
  wire trig    = sw_trg | ext_trg | (rc_hit & rc_trg);
  wire ld_a    = clk_en_q & ~ra_seq_q & edge_hit(ra_edge, a_rise, a_fall);
  wire ld_b    = clk_en_q &  ra_seq_q & edge_hit(rb_edge, a_rise, a_fall);
  wire ovf     = step & ~trig & (&cv_q);
  wire ovr     = (ld_a & ra_unread_q & ~rd_ra) | (ld_b & rb_unread_q & ~rd_rb);
  wire [7:0] st_set = {ext_trg, ld_b, ld_a, rc_hit, 2'b00, ovr, ovf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh <= '0; b_sh <= '0; x_sh <= '0; g_sh <= '0;
      psc_q <= '0; mode_q <= '0; rc_q <= '0; mask_q <= '0;
      cv_q <= '0; ra_q <= '0; rb_q <= '0; st_q <= '0;
      clk_en_q <= 1'b0; stop_q <= 1'b0; ra_seq_q <= 1'b0;
      ra_unread_q <= 1'b0; rb_unread_q <= 1'b0;
    end else begin
      a_sh <= {a_sh[1:0], in_a};
      b_sh <= {b_sh[1:0], in_b};
      x_sh <= {x_sh[1:0], ext_clk};
      g_sh <= {g_sh[0], ext_gate};
      psc_q <= psc_q + 1'b1;
      if (bus_wr && bus_addr == A_MODE) mode_q <= bus_wdata[14:0];
      if (bus_wr && bus_addr == A_RC)   rc_q <= bus_wdata[CW-1:0];
      if (bus_wr && bus_addr == A_MSET) mask_q <= mask_q | bus_wdata[7:0];
      else if (bus_wr && bus_addr == A_MCLR) mask_q <= mask_q & ~bus_wdata[7:0];

      if (trig)      cv_q <= '0;
      else if (step) cv_q <= cv_q + 1'b1;

      if (sw_dis)                clk_en_q <= 1'b0;
      else if (sw_en)            clk_en_q <= 1'b1;
      else if (ld_b && ldb_dis)  clk_en_q <= 1'b0;

      if (trig)                  stop_q <= 1'b0;
      else if (ld_b && ldb_stop) stop_q <= 1'b1;

      if (trig)      ra_seq_q <= 1'b0;
      else if (ld_a) ra_seq_q <= 1'b1;
      else if (ld_b) ra_seq_q <= 1'b0;

      if (ld_a) begin ra_q <= cv_q; ra_unread_q <= 1'b1; end
      else if (rd_ra) ra_unread_q <= 1'b0;
      if (ld_b) begin rb_q <= cv_q; rb_unread_q <= 1'b1; end
      else if (rd_rb) rb_unread_q <= 1'b0;

      st_q <= (rd_st ? 8'h00 : st_q) | st_set;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {17'b0, mode_q};
      A_CV:    bus_rdata = {{ZW{1'b0}}, cv_q};
      A_RA:    bus_rdata = {{ZW{1'b0}}, ra_q};
      A_RB:    bus_rdata = {{ZW{1'b0}}, rb_q};
      A_RC:    bus_rdata = {{ZW{1'b0}}, rc_q};
      A_ST:    bus_rdata = {13'b0, b_sh[1], a_sh[1], clk_en_q, 8'b0, st_q};
      A_MASK:  bus_rdata = {24'b0, mask_q};
      default: bus_rdata = 32'b0;
    endcase
  end

  assign irq = |(st_q & mask_q);

  a_r1_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_q && !trig) |=> $stable(cv_q));
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !trig && cv_q == {CW{1'b1}}) |=> (cv_q == '0 && st_q[0]));
  a_r4_rc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_hit && rc_trg) |=> (cv_q == '0 && st_q[4]));
  a_r5_rb_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ld_b |=> (rb_q == $past(cv_q) && !ra_seq_q && st_q[6]));
  a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && ra_unread_q && !rd_ra) |=> st_q[1]);
  a_r7_off_on_rb: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_b && ldb_dis && !sw_en) |=> !clk_en_q);
endmodule

// File: tb/capture_timer_tb_top.sv
module capture_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, ext_clk = 0, ext_gate = 0, in_a = 0, in_b = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  capture_timer dut_i (.clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_gate(ext_gate),
    .in_a(in_a), .in_b(in_b), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {ra_code, rb_code, expect A flag, expect B flag}
  localparam logic [5:0] VEC [6] = '{
    {2'd1, 2'd2, 1'b1, 1'b1}, {2'd0, 2'd2, 1'b0, 1'b0}, {2'd2, 2'd1, 1'b1, 1'b0},
    {2'd3, 2'd3, 1'b1, 1'b1}, {2'd1, 2'd1, 1'b1, 1'b0}, {2'd2, 2'd0, 1'b1, 1'b0}};

  function automatic logic [31:0] mk(int sel, int inv, int gt, int stp, int dis,
                                     int te, int tsa, int rct, int rae, int rbe);
    return 32'(sel | (inv << 3) | (gt << 4) | (stp << 5) | (dis << 6) | (te << 7) |
               (tsa << 9) | (rct << 10) | (rae << 11) | (rbe << 13));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a(input int w);
    in_a = 1; idle(w); in_a = 0; idle(w);
  endtask

  task automatic pulse_b(input int w);
    in_b = 1; idle(w); in_b = 0; idle(w);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, d2, ra, rb;
    int bad;
    idle(3); rst_n = 1; idle(1);

    // R11 reset state
    rd(6, d);  chk(d == 0, "R11 flags after reset", d, 0);
    rd(2, d);  chk(d == 0, "R11 counter after reset", d, 0);
    rd(9, d);  chk(d == 0, "R11 mask after reset", d, 0);
    rd(1, d);  chk(d == 0, "R11 mode after reset", d, 0);
    chk(irq == 0, "R11 irq after reset", irq, 0);

    // R1 off counter holds; disable wins
    idle(10); rd(2, d); chk(d == 0, "R1 counter held while off", d, 0);
    wr(0, 3); rd(6, d); chk(d[16] == 0, "R1 disable beats enable", d[16], 0);
    wr(0, 5); rd(2, d); idle(9); rd(2, d2);
    chk(d2 - d == 10, "R1 R2 counts every clock", d2 - d, 10);
    wr(0, 2); rd(2, d); idle(9); rd(2, d2);
    chk(d2 == d, "R1 stop holds value", d2, d);

    // R2 prescalers
    wr(1, mk(1,0,0,0,0,0,0,0,0,0)); wr(0, 5); rd(2, d); idle(39); rd(2, d2);
    chk(d2 - d == 10, "R2 divide by 4", d2 - d, 10);
    wr(1, mk(3,0,0,0,0,0,0,0,0,0)); rd(2, d); idle(639); rd(2, d2);
    chk(d2 - d == 10, "R2 divide by 64", d2 - d, 10);

    // R2 external clock polarity
    wr(1, mk(4,0,0,0,0,0,0,0,0,0)); wr(0, 4);
    ext_clk = 1; idle(5); rd(2, d); chk(d == 1, "R2 ext rising counts", d, 1);
    ext_clk = 0; idle(5); rd(2, d); chk(d == 1, "R2 ext falling ignored", d, 1);
    wr(1, mk(4,1,0,0,0,0,0,0,0,0)); wr(0, 4);
    ext_clk = 1; idle(5); rd(2, d); chk(d == 0, "R2 inverted ignores rising", d, 0);
    ext_clk = 0; idle(5); rd(2, d); chk(d == 1, "R2 inverted counts falling", d, 1);

    // R2 gating
    wr(1, mk(0,0,1,0,0,0,0,0,0,0)); wr(0, 4); idle(10); rd(2, d);
    chk(d == 0, "R2 gate low blocks", d, 0);
    ext_gate = 1; idle(3); rd(2, d); idle(9); rd(2, d2); ext_gate = 0;
    chk(d2 - d == 10, "R2 gate high counts", d2 - d, 10);

    // R4 compare restart
    wr(5, 4); wr(1, mk(0,0,0,0,0,0,0,1,0,0)); wr(0, 5); rd(6, d);
    bad = 0;
    for (int i = 0; i < 20; i++) begin rd(2, d); if (d > 4) bad++; end
    chk(bad == 0, "R4 counter bounded by C", bad, 0);
    rd(6, d); chk(d[4] == 1, "R4 compare flag", d[4], 1);

    // R5 edge codes via vector table
    foreach (VEC[k]) begin
      wr(1, mk(0,0,0,0,0,0,0,0,int'(VEC[k][5:4]),int'(VEC[k][3:2])));
      wr(0, 5); rd(6, d); rd(3, d); rd(4, d);
      pulse_a(7); idle(6);
      rd(6, d);
      chk(d[5] == VEC[k][1], $sformatf("R5 vec%0d A load", k), d[5], VEC[k][1]);
      chk(d[6] == VEC[k][0], $sformatf("R5 vec%0d B load", k), d[6], VEC[k][0]);
      if (VEC[k][0]) begin
        rd(3, ra); rd(4, rb);
        chk(rb - ra == 7, $sformatf("R5 vec%0d width", k), rb - ra, 7);
      end
    end

    // R9 read clears flags; level mirrors
    rd(6, d); chk(d[7:0] == 0, "R9 flags cleared by read", d[7:0], 0);
    in_a = 1; idle(3); rd(6, d);
    chk(d[18:17] == 2'b01, "R9 input mirrors", d[18:17], 1);
    in_a = 0; idle(3);

    // R6 overrun
    wr(1, mk(0,0,0,0,0,0,0,0,1,2)); wr(0, 5); rd(6, d); rd(3, d); rd(4, d);
    pulse_a(4); pulse_a(4); idle(4); rd(6, d);
    chk(d[1] == 1, "R6 overrun on unread reload", d[1], 1);
    rd(3, d); rd(4, d); wr(0, 4); rd(6, d);
    pulse_a(4); rd(3, d); rd(4, d); pulse_a(4); idle(4); rd(6, d);
    chk(d[1] == 0, "R6 no overrun when read", d[1], 0);

    // R7 freeze and off on B load
    wr(1, mk(0,0,0,1,0,0,0,0,1,2)); wr(0, 5);
    pulse_a(5); idle(6); rd(2, d); idle(10); rd(2, d2);
    chk(d2 == d, "R7 frozen after B load", d2, d);
    wr(0, 4); rd(2, d); idle(9); rd(2, d2);
    chk(d2 - d == 10, "R7 restart resumes", d2 - d, 10);
    wr(1, mk(0,0,0,0,1,0,0,0,1,2)); wr(0, 5);
    pulse_a(5); idle(6); rd(6, d);
    chk(d[16] == 0, "R7 turned off after B load", d[16], 0);

    // R8 external restart
    wr(1, mk(0,0,0,0,0,1,0,0,0,0)); wr(0, 5); idle(100); rd(6, d);
    pulse_b(3); rd(2, d); rd(6, d2);
    chk(d < 20, "R8 B edge restarts", d, 0);
    chk(d2[7] == 1, "R8 trigger flag", d2[7], 1);
    wr(1, mk(0,0,0,0,0,1,1,0,0,0)); idle(100); rd(6, d);
    pulse_b(3); rd(2, d); rd(6, d2);
    chk(d > 50 && d2[7] == 0, "R8 B ignored when source is A", d, 100);
    pulse_a(3); rd(6, d2);
    chk(d2[7] == 1, "R8 A edge restarts", d2[7], 1);

    // R10 interrupt mask
    wr(7, 32'h20); rd(9, d); chk(d == 32'h20, "R10 mask set", d, 32'h20);
    wr(1, mk(0,0,0,0,0,0,0,0,1,0)); wr(0, 5); rd(6, d); rd(3, d);
    chk(irq == 0, "R10 irq idle", irq, 0);
    pulse_a(3); chk(irq == 1, "R10 irq on A load", irq, 1);
    rd(6, d); #1 chk(irq == 0, "R10 irq clears on flag read", irq, 0);
    wr(8, 32'h20); wr(0, 4); pulse_a(3);
    chk(irq == 0, "R10 masked flag quiet", irq, 0);

    // R3 wrap
    wr(1, 0); wr(0, 5); rd(6, d); idle(65536 + 10); rd(6, d);
    chk(d[0] == 1, "R3 wrap flag", d[0], 1);
    rd(2, d); chk(d < 40, "R3 counter wrapped", d, 0);

    finish_run();
  end
endmodule